// File: doc/BRIEF.md
# Burst Mode Entry/Exit Controller

This block decides when a current-mode flyback controller drops into its low-power burst mode, how it switches while there, and when it leaves. A burst level (1, 2 or 3) is picked once from two level-select comparator flags while the supply is charging toward turn-on, and is held for the rest of the run. That level sets which reduced current limit the power stage uses during burst packets.

Once running, the feedback comparator that reports "below the chosen entry level" must stay set for a full qualification window, counted in microsecond ticks, before burst mode starts. Inside burst mode the gate is enabled when feedback climbs past the upper packet threshold and disabled when it falls past the lower one, with the previous state held in between. Feedback rising past the exit threshold leaves burst mode at once. All inputs are single-bit control flags and all outputs are plain levels, so there is no streaming interface and no back-pressure.

Top module: `burst_mode_ctrl`

## Requirements
- R1: While `startup_win` is 1 the level code follows the select flags; once `startup_win` is 0 the code does not change, whatever the select flags do.
- R2: The level code is 2'b11 when `sel_above_hi` is 1, 2'b10 when only `sel_above_lo` is 1, and 2'b01 when neither is 1; reset clears it to 2'b00.
- R3: Burst mode begins at the clock edge on which the `ENTRY_US`-th `us_tick` is seen while `fb_below_entry` has stayed 1 since the count began; from the next cycle `ilim_reduced` is 1 and `gate_en` is 0.
- R4: A cycle with `fb_below_entry` at 0 restarts the qualification count from zero.
- R5: In burst mode, `fb_above_pk_on` at 1 sets `gate_en` to 1 one cycle later; `fb_below_pk_off` at 1 (with `fb_above_pk_on` at 0) clears it one cycle later.
- R6: In burst mode, with the three packet/exit flags at 0, `gate_en` keeps its previous value.
- R7: `fb_above_exit` at 1 during burst mode leaves burst mode one cycle later: `gate_en` 1 and `ilim_reduced` 0; this takes priority over the packet flags.
- R8: No qualification counting and no burst entry while `startup_win` is 1 or while the level code is 2'b00.
- R9: Outside burst mode, including after reset, `gate_en` is 1 and `ilim_reduced` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| startup_win | input | 1 | High while the supply charges toward turn-on |
| sel_above_lo | input | 1 | Level-select pin above the lower select threshold |
| sel_above_hi | input | 1 | Level-select pin above the upper select threshold |
| fb_below_entry | input | 1 | Feedback below the selected entry level |
| fb_above_pk_on | input | 1 | Feedback above the packet-start threshold |
| fb_below_pk_off | input | 1 | Feedback below the packet-stop threshold |
| fb_above_exit | input | 1 | Feedback above the exit threshold |
| gate_en | output | 1 | Switching permitted |
| ilim_reduced | output | 1 | 1 selects the reduced burst current limit |
| level_code | output | 2 | Latched burst level code |

## Verification
The assertions assume the comparator flags are synchronous to `clk` and that `us_tick` is a single-cycle pulse; they also assume `sel_above_hi` implies `sel_above_lo` is meaningful only as a priority, not as a constraint. The stimulus changes every input only on the falling clock edge, keeps the packet-start and packet-stop flags from being set together except where priority is the point of the check, and shortens the qualification window through the parameter so the counting and restart paths are exercised in full.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } bm_level_e;
endpackage

// File: rtl/bm_level_latch.sv
module bm_level_latch
  import bm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startup_win,
  input  logic      sel_above_lo,
  input  logic      sel_above_hi,
  output bm_level_e level
);
  bm_level_e nxt;

  always_comb begin
    if (sel_above_hi)      nxt = LVL_HIGH;
    else if (sel_above_lo) nxt = LVL_MID;
    else                   nxt = LVL_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           level <= LVL_NONE;
    else if (startup_win) level <= nxt;
  end

  // R1: frozen outside the startup window
  assert_level_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_win |=> $stable(level));
  // R2: a sampled level is never the cleared code
  assert_level_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startup_win |=> level != LVL_NONE);
endmodule

// File: rtl/bm_entry_qual.sv
module bm_entry_qual #(
  parameter int ENTRY_US = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic us_tick,
  output logic qualified
);
  localparam int CW = $clog2(ENTRY_US + 1);
  localparam logic [CW-1:0] LAST = CW'(ENTRY_US - 1);

  logic [CW-1:0] cnt;

  assign qualified = arm && us_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!arm)     cnt <= '0;
    else if (us_tick)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R4: losing the condition restarts the count
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> cnt == '0);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/bm_burst_fsm.sv
module bm_burst_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic fb_above_pk_on,
  input  logic fb_below_pk_off,
  input  logic fb_above_exit,
  output logic in_burst,
  output logic packet_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst  <= 1'b0;
      packet_on <= 1'b0;
    end else if (!in_burst) begin
      in_burst  <= enter;
      packet_on <= 1'b0;
    end else if (fb_above_exit) begin
      in_burst  <= 1'b0;
      packet_on <= 1'b0;
    end else if (fb_above_pk_on) begin
      packet_on <= 1'b1;
    end else if (fb_below_pk_off) begin
      packet_on <= 1'b0;
    end
  end

  // R7: immediate exit
  assert_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && fb_above_exit |=> !in_burst);
  // R5: packet start and stop
  assert_pkt_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !fb_above_exit && fb_above_pk_on |=> packet_on);
  assert_pkt_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !fb_above_exit && !fb_above_pk_on && fb_below_pk_off |=> !packet_on);
  // R6: hysteresis hold
  assert_pkt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !fb_above_exit && !fb_above_pk_on && !fb_below_pk_off |=> $stable(packet_on));
  // R3: a new burst starts with the gate off
  assert_entry_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_burst) |-> !packet_on);
endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import bm_pkg::*;
#(
  parameter int ENTRY_US = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       startup_win,
  input  logic       sel_above_lo,
  input  logic       sel_above_hi,
  input  logic       fb_below_entry,
  input  logic       fb_above_pk_on,
  input  logic       fb_below_pk_off,
  input  logic       fb_above_exit,
  output logic       gate_en,
  output logic       ilim_reduced,
  output logic [1:0] level_code
);
  bm_level_e level;
  logic      arm, qualified, in_burst, packet_on;

  bm_level_latch u_level (
    .clk(clk), .rst_n(rst_n), .startup_win(startup_win),
    .sel_above_lo(sel_above_lo), .sel_above_hi(sel_above_hi), .level(level)
  );

  // R8: qualification only after a level has been chosen and the window closed
  assign arm = fb_below_entry && !in_burst && !startup_win && (level != LVL_NONE);

  bm_entry_qual #(.ENTRY_US(ENTRY_US)) u_qual (
    .clk(clk), .rst_n(rst_n), .arm(arm), .us_tick(us_tick), .qualified(qualified)
  );

  bm_burst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enter(qualified),
    .fb_above_pk_on(fb_above_pk_on), .fb_below_pk_off(fb_below_pk_off),
    .fb_above_exit(fb_above_exit), .in_burst(in_burst), .packet_on(packet_on)
  );

  assign gate_en      = !in_burst || packet_on;
  assign ilim_reduced = in_burst;
  assign level_code   = level;

  // R8: no burst starts during the startup window
  assert_no_entry_startup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    startup_win && !in_burst |=> !in_burst);
endmodule

// File: tb/tb_burst_mode_ctrl.sv
module tb_burst_mode_ctrl;
  localparam int ENTRY = 50;

  logic clk = 0, rst_n = 0;
  logic us_tick = 0, startup_win = 0, sel_lo = 0, sel_hi = 0;
  logic below = 0, pk_on = 0, pk_off = 0, ex = 0;
  logic gate_en, ilim_reduced;
  logic [1:0] level_code;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit tick_on = 0;

  burst_mode_ctrl #(.ENTRY_US(ENTRY)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .startup_win(startup_win),
    .sel_above_lo(sel_lo), .sel_above_hi(sel_hi), .fb_below_entry(below),
    .fb_above_pk_on(pk_on), .fb_below_pk_off(pk_off), .fb_above_exit(ex),
    .gate_en(gate_en), .ilim_reduced(ilim_reduced), .level_code(level_code)
  );

  always #5 clk = ~clk;

  // Reference model
  int  m_code = 0, m_ticks = 0;
  bit  m_burst = 0, m_gate = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_ticks = 0; m_burst = 0; m_gate = 0;
    end else begin
      bit was_burst;
      was_burst = m_burst;
      if (was_burst) begin
        if (ex) begin m_burst = 0; m_gate = 0; end
        else if (pk_on) m_gate = 1;
        else if (pk_off) m_gate = 0;
      end else if (below && !startup_win && m_code != 0) begin
        if (us_tick) m_ticks++;
        if (m_ticks >= ENTRY) begin m_burst = 1; m_gate = 0; m_ticks = 0; end
      end else begin
        m_ticks = 0;
      end
      if (startup_win) m_code = sel_hi ? 3 : (sel_lo ? 2 : 1);
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 level_code", level_code, m_code);
      chk("R5 gate_en", gate_en, (!m_burst || m_gate) ? 1 : 0);
      chk("R3 ilim_reduced", ilim_reduced, m_burst ? 1 : 0);
    end
    us_tick <= tick_on && (cyc % 2 == 0);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; wait_cyc(2); rst_n = 1; wait_cyc(1);
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(1);
    // R9 / R2: reset state
    chk("R9 reset gate_en", gate_en, 1);
    chk("R9 reset ilim", ilim_reduced, 0);
    chk("R2 reset code", level_code, 0);
    rst_n = 1;
    tick_on = 1;
    // R8: level code 0, no startup yet -> no entry
    below = 1; wait_cyc(3 * ENTRY);
    chk("R8 no entry with code 0", ilim_reduced, 0);
    // R1/R2: startup window, mid level
    below = 1; startup_win = 1; sel_lo = 1; sel_hi = 0; wait_cyc(3 * ENTRY);
    chk("R8 no entry in window", ilim_reduced, 0);
    chk("R2 mid code", level_code, 2);
    startup_win = 0; below = 0; sel_lo = 0; sel_hi = 1; wait_cyc(5);
    chk("R1 frozen code", level_code, 2);
    // R4: hold then release partway, then a long hold
    below = 1; wait_cyc(ENTRY); below = 0; wait_cyc(1); below = 1;
    wait_cyc(ENTRY + 10);
    chk("R4 restarted no entry", ilim_reduced, 0);
    wait_cyc(ENTRY);
    chk("R3 entered", ilim_reduced, 1);
    chk("R3 gate off on entry", gate_en, 0);
    below = 0;
    // R5/R6 packets
    pk_on = 1; wait_cyc(1); pk_on = 0; wait_cyc(1);
    chk("R5 packet on", gate_en, 1);
    wait_cyc(4);
    chk("R6 hold on", gate_en, 1);
    pk_off = 1; wait_cyc(1); pk_off = 0; wait_cyc(1);
    chk("R5 packet off", gate_en, 0);
    wait_cyc(4);
    chk("R6 hold off", gate_en, 0);
    // R7 exit with priority over packet flag
    pk_on = 1; ex = 1; wait_cyc(1); pk_on = 0; ex = 0; wait_cyc(1);
    chk("R7 exit ilim", ilim_reduced, 0);
    chk("R7 exit gate", gate_en, 1);
    // High and low levels after fresh resets
    do_reset;
    startup_win = 1; sel_hi = 1; sel_lo = 0; wait_cyc(4); startup_win = 0; wait_cyc(1);
    chk("R2 high code", level_code, 3);
    do_reset;
    startup_win = 1; sel_hi = 0; sel_lo = 0; wait_cyc(4); startup_win = 0;
    sel_hi = 1; wait_cyc(2);
    chk("R2 low code", level_code, 1);
    chk("R1 frozen low", level_code, 1);
    below = 1; wait_cyc(2 * ENTRY + 6);
    chk("R3 entered low level", ilim_reduced, 1);
    ex = 1; wait_cyc(1); ex = 0; below = 0; wait_cyc(2);
    chk("R9 idle after exit", gate_en, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule